// File: doc/BRIEF.md
# Predicated Vector Element Sequencer

This block walks the element positions of one predicated vector operation. Software supplies a vector length of up to 64 and two 64-bit predicate masks, one for sources and one for destinations, together with a zeroing flag for each side. A one-cycle `start` pulse captures all of this. The sequencer then presents one element at a time to the issue stage. Each element carries a source index, a destination index and two flags. One flag tells the operand path to supply zeros instead of reading registers. The other tells the result path to write a zero result and mark the condition as "equal to zero".

Each side steps in one of two ways. If that side's zeroing flag is clear, the index jumps in a single cycle to the next set predicate bit below the vector length, so clear bits cost no cycles. If the flag is set, the index visits every position in turn. When both zeroing flags are set, the destination mask is narrowed to the bits also set in the source mask before the first element is searched. The run ends when either side has no further eligible position. A one-cycle `done` follows, and the sequencer goes back to idle.

Top module: `pred_elem_seq`

## Requirements
- R1: A synchronous active-high `rst` puts the sequencer in idle within one clock, even in the middle of a run. In idle `issue_valid` and `done` are low and both step indices read zero.
- R2: A `start` seen in idle captures `vl`, both masks and both zeroing flags. If an eligible element exists, `issue_valid` is high in the next cycle and shows the first element.
- R3: For a side whose zeroing flag is clear, every index issued on that side is a set bit of that side's mask. Each handshake (`issue_valid` and `ready` both high) moves the index to the lowest set bit above the current one, in one cycle.
- R4: For a side whose zeroing flag is set, the index starts at 0 and rises by exactly one on each handshake.
- R5: Only positions below `vl` are eligible. Mask bits at or above `vl` have no effect. `vl` may be 0 to 64, and index 63 is reachable.
- R6: With both zeroing flags set, the destination mask used for the run is `dst_mask & src_mask`. With only one flag set, the masks are used as given.
- R7: While `issue_valid` is high, `issue_zero_res` and `issue_cr_eq` are 1 exactly when destination zeroing is on and the destination mask bit at `issue_dst_idx` is 0.
- R8: While `issue_valid` is high, `issue_zero_ops` is 1 exactly when `issue_zero_res` is 0, source zeroing is on, and the source mask bit at `issue_src_idx` is 0. The two flags are never high together.
- R9: While `issue_valid` is high and `ready` is low, the element is held: valid stays high and both indices and flags stay unchanged.
- R10: `done` is high for exactly one cycle. It comes in the cycle after the handshake that leaves either side with no further eligible position. If no element is eligible at `start`, it comes in the cycle after `start`. The next cycle is idle, and a new `start` is accepted there.
- R11: A `start` pulse during a run is ignored. The run continues with its captured length, masks and flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; sampled only in idle |
| vl | input | 7 | Vector length, 0 to 64 |
| src_mask | input | 64 | Source predicate mask |
| dst_mask | input | 64 | Destination predicate mask |
| src_zero | input | 1 | Source zeroing enable |
| dst_zero | input | 1 | Destination zeroing enable |
| ready | input | 1 | Downstream accepts the presented element |
| issue_valid | output | 1 | An element is being presented |
| issue_src_idx | output | 6 | Source element index |
| issue_dst_idx | output | 6 | Destination element index |
| issue_zero_ops | output | 1 | Feed zero operands instead of reading registers |
| issue_zero_res | output | 1 | Write a zero result |
| issue_cr_eq | output | 1 | Condition indication "equal to zero" for a zeroed result |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The hardest situations to reach are runs where the two sides fall out of step. One side jumps over sparse mask bits while the other walks every position, so the run ends because one side runs out while the other still has bits left. Mask bits just above `vl`, and a single bit at position 63 with `vl` at 64, are also hard to reach. Directed runs set these up with hand-picked masks and known element counts. Many further runs draw masks from ANDed random words so that set bits are sparse, toggle `ready` at random to hold elements mid-run, and pulse `start` while busy. A reset is also applied in the middle of a run.

// File: rtl/pes_pkg.sv
package pes_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_RUN  = 2'd1,
      SEQ_DONE = 2'd2
   } seq_state_e;

   // Width of a field that must hold at least one bit
   function automatic int width_min1(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/pes_next_set.sv
// Finds the lowest eligible position at or above `base` and below `limit`.
// When `fill` is set every position counts as eligible (unit stepping).
module pes_next_set #(
   parameter  int N     = 64,
   parameter  int CHUNK = 8,
   localparam int IDX_W = pes_pkg::width_min1(N),
   localparam int VL_W  = $clog2(N + 1)
) (
   input  logic [N-1:0]     mask,
   input  logic             fill,
   input  logic [VL_W-1:0]  limit,
   input  logic [VL_W-1:0]  base,
   output logic             found,
   output logic [IDX_W-1:0] idx
);

   logic [N-1:0] cand;

   for (genvar i = 0; i < N; i++) begin : g_cand
      assign cand[i] = (fill | mask[i]) &&
                       (VL_W'(i) < limit) &&
                       (VL_W'(i) >= base);
   end

   if (CHUNK <= 1 || CHUNK >= N) begin : g_flat
      // single priority chain across all positions
      always_comb begin
         found = 1'b0;
         idx   = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
               found = 1'b1;
               idx   = IDX_W'(i);
            end
         end
      end
   end else begin : g_two_level
      // group any-bits first, then the lowest bit inside the chosen group
      localparam int NGRP = (N + CHUNK - 1) / CHUNK;
      localparam int PADW = NGRP * CHUNK;

      logic [PADW-1:0] padded;
      logic [NGRP-1:0] grp_any;

      assign padded = PADW'(cand);

      for (genvar g = 0; g < NGRP; g++) begin : g_grp
         assign grp_any[g] = |padded[g*CHUNK +: CHUNK];
      end

      always_comb begin
         int gsel;
         int off;
         gsel  = 0;
         off   = 0;
         found = |grp_any;
         for (int g = NGRP - 1; g >= 0; g--) begin
            if (grp_any[g]) gsel = g;
         end
         for (int b = CHUNK - 1; b >= 0; b--) begin
            if (padded[gsel*CHUNK + b]) off = b;
         end
         idx = IDX_W'(gsel * CHUNK + off);
      end
   end

endmodule

// File: rtl/pes_zero_rules.sv
// Per-element zeroing decisions; result zeroing takes precedence.
module pes_zero_rules (
   input  logic active,
   input  logic src_bit,
   input  logic dst_bit,
   input  logic src_zero,
   input  logic dst_zero,
   output logic zero_ops,
   output logic zero_res,
   output logic cr_eq
);

   logic res_kill;

   assign res_kill = active & dst_zero & ~dst_bit;
   assign zero_res = res_kill;
   assign cr_eq    = res_kill;
   assign zero_ops = active & ~res_kill & src_zero & ~src_bit;

endmodule

// File: rtl/pred_elem_seq.sv
module pred_elem_seq #(
   parameter  int MAX_VL = 64,
   parameter  int CHUNK  = 8,
   localparam int IDX_W  = pes_pkg::width_min1(MAX_VL),
   localparam int VL_W   = $clog2(MAX_VL + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [VL_W-1:0]   vl,
   input  logic [MAX_VL-1:0] src_mask,
   input  logic [MAX_VL-1:0] dst_mask,
   input  logic              src_zero,
   input  logic              dst_zero,
   input  logic              ready,
   output logic              issue_valid,
   output logic [IDX_W-1:0]  issue_src_idx,
   output logic [IDX_W-1:0]  issue_dst_idx,
   output logic              issue_zero_ops,
   output logic              issue_zero_res,
   output logic              issue_cr_eq,
   output logic              done
);

   import pes_pkg::*;

   localparam int SIDES = 2;   // 0: source, 1: destination

   if (MAX_VL < 2) begin : g_bad_len
      $error("pred_elem_seq: MAX_VL must be at least 2");
   end
   if (CHUNK < 1) begin : g_bad_chunk
      $error("pred_elem_seq: CHUNK must be at least 1");
   end

   seq_state_e              state_q;
   logic [VL_W-1:0]         vl_q;
   logic [MAX_VL-1:0]       smask_q;
   logic [MAX_VL-1:0]       dmask_q;
   logic                    szero_q;
   logic                    dzero_q;
   logic [IDX_W-1:0]        src_idx_q;
   logic [IDX_W-1:0]        dst_idx_q;

   logic                    idle;
   logic [MAX_VL-1:0]       start_dmask;
   logic [VL_W-1:0]         srch_limit;
   logic [SIDES-1:0][MAX_VL-1:0] srch_mask;
   logic [SIDES-1:0]        srch_fill;
   logic [SIDES-1:0][VL_W-1:0]   srch_base;
   logic [SIDES-1:0]        srch_found;
   logic [SIDES-1:0][IDX_W-1:0]  srch_idx;
   logic                    both_found;
   logic                    handshake;

   assign idle        = (state_q == SEQ_IDLE);
   assign handshake   = (state_q == SEQ_RUN) && ready;
   // merged zeroing: destination narrowed to the source predicate
   assign start_dmask = (src_zero && dst_zero) ? (dst_mask & src_mask) : dst_mask;

   // In idle the searchers look at the incoming request from position 0;
   // during a run they look at the captured request above the current index.
   always_comb begin
      srch_limit   = idle ? vl : vl_q;
      srch_mask[0] = idle ? src_mask : smask_q;
      srch_mask[1] = idle ? start_dmask : dmask_q;
      srch_fill[0] = idle ? src_zero : szero_q;
      srch_fill[1] = idle ? dst_zero : dzero_q;
      srch_base[0] = idle ? '0 : VL_W'(src_idx_q) + VL_W'(1);
      srch_base[1] = idle ? '0 : VL_W'(dst_idx_q) + VL_W'(1);
   end

   for (genvar k = 0; k < SIDES; k++) begin : g_side
      pes_next_set #(
         .N     (MAX_VL),
         .CHUNK (CHUNK)
      ) u_search (
         .mask  (srch_mask[k]),
         .fill  (srch_fill[k]),
         .limit (srch_limit),
         .base  (srch_base[k]),
         .found (srch_found[k]),
         .idx   (srch_idx[k])
      );
   end

   assign both_found = &srch_found;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= SEQ_IDLE;
         vl_q      <= '0;
         smask_q   <= '0;
         dmask_q   <= '0;
         szero_q   <= 1'b0;
         dzero_q   <= 1'b0;
         src_idx_q <= '0;
         dst_idx_q <= '0;
      end else begin
         unique case (state_q)
            SEQ_IDLE: begin
               if (start) begin
                  vl_q    <= vl;
                  smask_q <= src_mask;
                  dmask_q <= start_dmask;
                  szero_q <= src_zero;
                  dzero_q <= dst_zero;
                  if (both_found) begin
                     src_idx_q <= srch_idx[0];
                     dst_idx_q <= srch_idx[1];
                     state_q   <= SEQ_RUN;
                  end else begin
                     state_q   <= SEQ_DONE;
                  end
               end
            end
            SEQ_RUN: begin
               if (handshake) begin
                  if (both_found) begin
                     src_idx_q <= srch_idx[0];
                     dst_idx_q <= srch_idx[1];
                  end else begin
                     state_q   <= SEQ_DONE;
                  end
               end
            end
            SEQ_DONE: begin
               state_q   <= SEQ_IDLE;
               src_idx_q <= '0;
               dst_idx_q <= '0;
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   pes_zero_rules u_zero (
      .active   (state_q == SEQ_RUN),
      .src_bit  (smask_q[src_idx_q]),
      .dst_bit  (dmask_q[dst_idx_q]),
      .src_zero (szero_q),
      .dst_zero (dzero_q),
      .zero_ops (issue_zero_ops),
      .zero_res (issue_zero_res),
      .cr_eq    (issue_cr_eq)
   );

   assign issue_valid   = (state_q == SEQ_RUN);
   assign issue_src_idx = src_idx_q;
   assign issue_dst_idx = dst_idx_q;
   assign done          = (state_q == SEQ_DONE);

endmodule

// File: rtl/pes_seq_chk.sv
module pes_seq_chk #(
   parameter  int MAX_VL = 64,
   localparam int IDX_W  = pes_pkg::width_min1(MAX_VL),
   localparam int VL_W   = $clog2(MAX_VL + 1)
) (
   input logic              clk,
   input logic              rst,
   input logic              ready,
   input logic              issue_valid,
   input logic [IDX_W-1:0]  src_idx,
   input logic [IDX_W-1:0]  dst_idx,
   input logic              zero_ops,
   input logic              zero_res,
   input logic              cr_eq,
   input logic              done,
   input logic [VL_W-1:0]   vl_q,
   input logic [MAX_VL-1:0] smask_q,
   input logic [MAX_VL-1:0] dmask_q,
   input logic              szero_q,
   input logic              dzero_q
);

   // R5
   idx_below_len_chk: assert property (@(posedge clk) disable iff (rst)
      issue_valid |-> (VL_W'(src_idx) < vl_q) && (VL_W'(dst_idx) < vl_q));

   // R3
   src_on_set_bit_chk: assert property (@(posedge clk) disable iff (rst)
      (issue_valid && !szero_q) |-> smask_q[src_idx]);

   // R3
   dst_on_set_bit_chk: assert property (@(posedge clk) disable iff (rst)
      (issue_valid && !dzero_q) |-> dmask_q[dst_idx]);

   // R3
   idx_rising_chk: assert property (@(posedge clk) disable iff (rst)
      (issue_valid && $past(issue_valid && ready)) |->
         (src_idx > $past(src_idx)) && (dst_idx > $past(dst_idx)));

   // R4
   src_unit_step_chk: assert property (@(posedge clk) disable iff (rst)
      (issue_valid && szero_q && $past(issue_valid && ready)) |->
         (src_idx == $past(src_idx) + IDX_W'(1)));

   // R4
   dst_unit_step_chk: assert property (@(posedge clk) disable iff (rst)
      (issue_valid && dzero_q && $past(issue_valid && ready)) |->
         (dst_idx == $past(dst_idx) + IDX_W'(1)));

   // R6
   merged_mask_subset_chk: assert property (@(posedge clk) disable iff (rst)
      (issue_valid && szero_q && dzero_q && dmask_q[dst_idx]) |-> smask_q[dst_idx]);

   // R7
   result_zeroed_chk: assert property (@(posedge clk) disable iff (rst)
      (issue_valid && dzero_q && !dmask_q[dst_idx]) |-> (zero_res && cr_eq));

   // R8
   flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
      !(zero_ops && zero_res));

   // R9
   stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (issue_valid && !ready) |=>
         (issue_valid && $stable(src_idx) && $stable(dst_idx)));

   // R10
   done_single_chk: assert property (@(posedge clk) disable iff (rst)
      done |=> (!done && !issue_valid));

   // R10
   done_not_valid_chk: assert property (@(posedge clk) disable iff (rst)
      !(done && issue_valid));

endmodule

bind pred_elem_seq pes_seq_chk #(.MAX_VL(MAX_VL)) u_seq_chk (
   .clk         (clk),
   .rst         (rst),
   .ready       (ready),
   .issue_valid (issue_valid),
   .src_idx     (issue_src_idx),
   .dst_idx     (issue_dst_idx),
   .zero_ops    (issue_zero_ops),
   .zero_res    (issue_zero_res),
   .cr_eq       (issue_cr_eq),
   .done        (done),
   .vl_q        (vl_q),
   .smask_q     (smask_q),
   .dmask_q     (dmask_q),
   .szero_q     (szero_q),
   .dzero_q     (dzero_q)
);

// File: tb/pred_elem_seq_test.sv
`timescale 1ns/1ps
module pred_elem_seq_test;

   localparam int N  = 64;
   localparam int VW = 7;
   localparam int IW = 6;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          start = 1'b0;
   logic [VW-1:0] vl = '0;
   logic [N-1:0]  src_mask = '0;
   logic [N-1:0]  dst_mask = '0;
   logic          src_zero = 1'b0;
   logic          dst_zero = 1'b0;
   logic          ready = 1'b1;
   logic          issue_valid;
   logic [IW-1:0] issue_src_idx;
   logic [IW-1:0] issue_dst_idx;
   logic          issue_zero_ops;
   logic          issue_zero_res;
   logic          issue_cr_eq;
   logic          done;

   always #2.5 clk = ~clk;

   pred_elem_seq uut (
      .clk(clk), .rst(rst), .start(start), .vl(vl),
      .src_mask(src_mask), .dst_mask(dst_mask),
      .src_zero(src_zero), .dst_zero(dst_zero), .ready(ready),
      .issue_valid(issue_valid), .issue_src_idx(issue_src_idx),
      .issue_dst_idx(issue_dst_idx), .issue_zero_ops(issue_zero_ops),
      .issue_zero_res(issue_zero_res), .issue_cr_eq(issue_cr_eq),
      .done(done)
   );

   int checks = 0;
   int fails  = 0;
   int hs_count = 0;
   bit rnd_ready = 1'b0;

   // reference model: 0 idle, 1 issuing, 2 done
   int mstate = 0;
   int qs[$];
   int qd[$];
   bit qzo[$];
   bit qzr[$];

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int nxt(input logic [N-1:0] m, input bit fill, input int len, input int from);
      for (int i = from + 1; i < len; i++)
         if (fill || m[i]) return i;
      return -1;
   endfunction

   function automatic void build();
      logic [N-1:0] em;
      int s;
      int d;
      bit zr;
      em = (src_zero && dst_zero) ? (dst_mask & src_mask) : dst_mask;
      s = nxt(src_mask, src_zero, int'(vl), -1);
      d = nxt(em, dst_zero, int'(vl), -1);
      while (s >= 0 && d >= 0) begin
         zr = dst_zero && !em[d];
         qs.push_back(s);
         qd.push_back(d);
         qzr.push_back(zr);
         qzo.push_back(!zr && src_zero && !src_mask[s]);
         s = nxt(src_mask, src_zero, int'(vl), s);
         d = nxt(em, dst_zero, int'(vl), d);
      end
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         mstate = 0;
         qs.delete(); qd.delete(); qzo.delete(); qzr.delete();
      end else begin
         case (mstate)
            0: if (start) begin
                  build();
                  mstate = (qs.size() > 0) ? 1 : 2;
               end
            1: if (ready) begin
                  void'(qs.pop_front()); void'(qd.pop_front());
                  void'(qzo.pop_front()); void'(qzr.pop_front());
                  hs_count++;
                  if (qs.size() == 0) mstate = 2;
               end
            default: mstate = 0;
         endcase
      end
   end

   // compare every cycle, at the falling edge
   always @(negedge clk) begin
      if (!rst) begin
         chk(issue_valid === (mstate == 1), "R2 valid", issue_valid, mstate == 1);
         chk(done === (mstate == 2), "R10 done", done, mstate == 2);
         if (mstate == 1 && issue_valid === 1'b1) begin
            chk(int'(issue_src_idx) == qs[0], "R3 src index", issue_src_idx, qs[0]);
            chk(int'(issue_dst_idx) == qd[0], "R3 dst index", issue_dst_idx, qd[0]);
            chk(issue_zero_res === qzr[0], "R7 zero result", issue_zero_res, qzr[0]);
            chk(issue_cr_eq === qzr[0], "R7 cr eq", issue_cr_eq, qzr[0]);
            chk(issue_zero_ops === qzo[0], "R8 zero operands", issue_zero_ops, qzo[0]);
         end
      end
   end

   always @(negedge clk) begin
      #1;
      ready = rnd_ready ? 1'($urandom) : 1'b1;
   end

   task automatic drive_start(input int v, input logic [N-1:0] s, input logic [N-1:0] d,
                              input bit sz, input bit dz);
      @(negedge clk); #1;
      vl = VW'(v); src_mask = s; dst_mask = d; src_zero = sz; dst_zero = dz;
      start = 1'b1;
      hs_count = 0;
      @(negedge clk); #1;
      start = 1'b0;
   endtask

   task automatic finish_run(input int exp_n, input string req);
      while (done !== 1'b1) @(negedge clk);
      if (exp_n >= 0) chk(hs_count == exp_n, req, hs_count, exp_n);
      @(negedge clk);
      chk(!issue_valid && !done, "R10 back to idle", {issue_valid, done}, 0);
   endtask

   task automatic run(input int v, input logic [N-1:0] s, input logic [N-1:0] d,
                      input bit sz, input bit dz, input int exp_n, input string req);
      drive_start(v, s, d, sz, dz);
      finish_run(exp_n, req);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!issue_valid && !done, "R1 reset outputs", {issue_valid, done}, 0);
      chk(issue_src_idx == 0 && issue_dst_idx == 0, "R1 reset indices",
          {issue_src_idx, issue_dst_idx}, 0);
      #1 rst = 1'b0;

      // R3 skip on both sides; dst runs out first
      run(16, 64'h00F1, 64'h8421, 1'b0, 1'b0, 4, "R3 skip count");
      // R4 source walks every element, zero operands on clear bits (R8)
      run(6, 64'h5, '1, 1'b1, 1'b0, 6, "R4 unit step count");
      // R7 destination zeroing
      run(5, '1, 64'h12, 1'b0, 1'b1, 5, "R7 dst zeroing count");
      // R6 both zeroing: merged mask
      run(8, 64'h0F, 64'h3C, 1'b1, 1'b1, 8, "R6 merged count");
      // R6 source zeroing alone leaves dst mask untouched
      run(8, 64'h0F, 64'h3C, 1'b1, 1'b0, 4, "R6 no merge count");
      // R5 bits above vl ignored
      run(4, 64'hFFFF_0000_0000_0008, '1, 1'b0, 1'b0, 1, "R5 above vl count");
      // R5 full length, index 63 reachable
      run(64, 64'h8000_0000_0000_0001, '1, 1'b0, 1'b0, 2, "R5 full length count");
      // R10 nothing eligible
      run(8, 64'h100, '1, 1'b0, 1'b0, 0, "R10 empty count");
      run(0, '1, '1, 1'b1, 1'b1, 0, "R10 zero length count");

      // R9 stalls from random ready
      rnd_ready = 1'b1;
      run(20, '1, 64'hA_AAAA, 1'b0, 1'b0, 10, "R9 stalled count");

      // R11 start while busy is ignored
      drive_start(12, 64'hFFF, 64'hFFF, 1'b0, 1'b0);
      @(negedge clk); #1;
      vl = 7'd3; src_mask = 64'h1; dst_mask = 64'h1; start = 1'b1;
      @(negedge clk); #1;
      start = 1'b0;
      finish_run(12, "R11 busy start count");

      // R1 reset during a run
      drive_start(30, '1, '1, 1'b0, 1'b0);
      @(negedge clk); #1 rst = 1'b1;
      @(negedge clk);
      chk(!issue_valid && !done, "R1 mid-run reset outputs", {issue_valid, done}, 0);
      chk(issue_src_idx == 0 && issue_dst_idx == 0, "R1 mid-run reset indices",
          {issue_src_idx, issue_dst_idx}, 0);
      #1 rst = 1'b0;

      // random sparse runs
      for (int r = 0; r < 40; r++) begin
         logic [N-1:0] rs;
         logic [N-1:0] rd;
         rs = {$urandom, $urandom} & {$urandom, $urandom};
         rd = {$urandom, $urandom} & {$urandom, $urandom};
         run(int'($urandom_range(0, 64)), rs, rd, 1'($urandom), 1'($urandom), -1, "R2 random");
      end

      rnd_ready = 1'b0;
      repeat (2) @(negedge clk);
      summary();
      $finish;
   end

endmodule